// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Byte Queues

This block is a serial port that software drives through a small window of word-sized registers on a request/done slave port. A receiver decodes 8N1 frames from the input line and pushes each good byte into a receive queue. Software polls a ready flag and pops bytes by reading a data register.

Transmission is done in batches. Software first checks a full flag and pushes bytes into a transmit queue. It then writes 1 to a go register. The block drains the whole queue onto the output line, one frame after another, and then clears the go register. Software can poll that register to learn when the batch has left the wire.

The interconnect routes the register window to this block. The block itself decodes only address bits [4:2]. The bit period is set by a clock-divisor parameter, and each queue depth is a power of two set by a parameter. The default depth is 4096 bytes.

Top module: `serial_mmio_port`

## Requirements
- R1: After reset the output line is high, and reads of word offsets 0, 2, 3 and 4 return 0.
- R2: A request that is not already being answered gets `reqDone` high for exactly one cycle, on the clock after it is seen. Address bits [4:2] select the register.
- R3: Offset 0 (receive-ready) reads 1 in bit 0 while the receive queue holds at least one byte, and 0 otherwise. Bits 31:1 are 0.
- R4: A read of offset 1 (receive-data) returns the oldest queued byte in bits 7:0, with bits 31:8 at 0, and removes that byte. Bytes come out in arrival order.
- R5: A read of offset 1 while the receive queue is empty returns 0 and leaves the queue unchanged.
- R6: The receiver takes 8N1 frames, least significant bit first, at CLKS_PER_BIT clocks per bit. It checks the start bit again at mid-bit, so a low pulse shorter than half a bit produces no byte.
- R7: A frame whose stop bit samples low is discarded, and the receiver still accepts the next good frame.
- R8: When the receive queue is full, newly received bytes are dropped and the bytes already stored are kept.
- R9: A write to offset 5 (transmit-data) appends bits 7:0 to the transmit queue. Offset 3 (transmit-full) reads 1 while that queue is full. A write to offset 5 while the queue is full changes nothing.
- R10: Writing offset 4 (transmit-go) with bit 0 = 1 sets it. It reads 1 until the queue is empty and the last stop bit has ended, then reads 0. Writing it with bit 0 = 0 has no effect, and no byte leaves while it is 0.
- R11: While transmit-go is set, queued bytes are sent as 8N1 frames, least significant bit first, in push order. The line is high whenever nothing is being sent. Offset 2 (transmit-busy) reads 1 while a frame is being shifted out.
- R12: Offsets 6 and 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqRead | input | 1 | Read request, held until done |
| reqWrite | input | 1 | Write request, held until done |
| reqAddr | input | 32 | Byte address; bits [4:2] pick the register |
| reqWdata | input | 32 | Write data |
| reqDone | output | 1 | One-cycle completion pulse |
| reqRdata | output | 32 | Read data, valid with reqDone |
| rxLine | input | 1 | Serial input, idle high |
| txLine | output | 1 | Serial output, idle high |

## Verification
The bound checker watches the rules that hold on every cycle:
- the completion pulse is one cycle long and follows each new request;
- the output line stays high while the transmitter is idle;
- transmit-go only drops once the queue is empty and the shifter has finished;
- a write into a full, non-draining transmit queue leaves it full;
- a read of an empty receive queue returns zero.

Data ordering, bit timing, glitch and bad-stop rejection, and overflow drops show only in the bench's scenarios. These include a sweep that fills the small bench configuration past its depth in both directions, and a loopback run from the transmit line into the receiver.

// File: rtl/serial_mmio_pkg.sv
package serial_mmio_pkg;

  // Strobes from the register control into the datapath
  typedef struct packed {
    logic rxPop;
    logic txPush;
  } ctrlStrobe_t;

  // Word offsets inside the register window (decoded from address bits [4:2])
  localparam logic [2:0] OFF_RX_READY = 3'd0;
  localparam logic [2:0] OFF_RX_DATA  = 3'd1;
  localparam logic [2:0] OFF_TX_BUSY  = 3'd2;
  localparam logic [2:0] OFF_TX_FULL  = 3'd3;
  localparam logic [2:0] OFF_TX_GO    = 3'd4;
  localparam logic [2:0] OFF_TX_DATA  = 3'd5;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rxState_t;

endpackage

// File: rtl/serial_byte_fifo.sv
module serial_byte_fifo #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic              empty,
  output logic              full
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] LEVEL_FULL = (ADDR_W + 1)'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic [ADDR_W:0]   level;
  logic              doPush;
  logic              doPop;

  assign empty    = (level == '0);
  assign full     = (level == LEVEL_FULL);
  // A push into a full queue or a pop from an empty one is dropped here
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      unique case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
  parameter int CLKS_PER_BIT = 347
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] data,
  output logic       busy,
  output logic       line
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [3:0] FRAME_LAST = 4'd9;

  logic [9:0]       shiftReg;
  logic [3:0]       bitIdx;
  logic [CNT_W-1:0] clkCnt;

  assign line = busy ? shiftReg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      shiftReg <= '1;
      bitIdx   <= '0;
      clkCnt   <= '0;
    end else if (!busy) begin
      if (start) begin
        shiftReg <= {1'b1, data, 1'b0};
        busy     <= 1'b1;
        bitIdx   <= '0;
        clkCnt   <= '0;
      end
    end else if (clkCnt == BIT_LAST) begin
      clkCnt <= '0;
      if (bitIdx == FRAME_LAST) begin
        busy <= 1'b0;
      end else begin
        bitIdx   <= bitIdx + 1'b1;
        shiftReg <= {1'b1, shiftReg[9:1]};
      end
    end else begin
      clkCnt <= clkCnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_mmio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 347
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       line,
  output logic       byteDone,
  output logic [7:0] byteData
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLKS_PER_BIT / 2 - 1);

  logic             lineMeta;
  logic             lineSync;
  rxState_t         state;
  logic [CNT_W-1:0] clkCnt;
  logic [2:0]       bitIdx;
  logic [7:0]       shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineMeta <= 1'b1;
      lineSync <= 1'b1;
    end else begin
      lineMeta <= line;
      lineSync <= lineMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      clkCnt   <= '0;
      bitIdx   <= '0;
      shiftReg <= '0;
      byteDone <= 1'b0;
      byteData <= '0;
    end else begin
      byteDone <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          clkCnt <= '0;
          if (!lineSync) state <= RX_START;
        end
        RX_START: begin
          if (clkCnt == HALF_LAST) begin
            clkCnt <= '0;
            bitIdx <= '0;
            state  <= lineSync ? RX_IDLE : RX_BITS;
          end else begin
            clkCnt <= clkCnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (clkCnt == BIT_LAST) begin
            clkCnt   <= '0;
            shiftReg <= {lineSync, shiftReg[7:1]};
            if (bitIdx == 3'd7) state <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            clkCnt <= clkCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (clkCnt == BIT_LAST) begin
            clkCnt <= '0;
            state  <= RX_IDLE;
            if (lineSync) begin
              byteDone <= 1'b1;
              byteData <= shiftReg;
            end
          end else begin
            clkCnt <= clkCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_datapath.sv
module serial_datapath
  import serial_mmio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 347,
  parameter int FIFO_ADDR_W  = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic [7:0]  txByte,
  input  logic        sendActive,
  input  logic        rxLine,
  output logic [7:0]  rxHead,
  output logic        rxEmpty,
  output logic        txFull,
  output logic        txEmpty,
  output logic        txBusy,
  output logic        txLine
);
  logic       rxDone;
  logic [7:0] rxByte;
  logic       rxFull;
  logic [7:0] txHead;
  logic       txLaunch;
  logic       unusedRxFull;

  // A full receive queue drops the new byte inside the queue
  assign unusedRxFull = rxFull;
  // Start the next frame when draining, the shifter is idle and a byte waits
  assign txLaunch = sendActive && !txBusy && !txEmpty;

  serial_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rx_i (
    .clk      (clk),
    .rstN     (rstN),
    .line     (rxLine),
    .byteDone (rxDone),
    .byteData (rxByte)
  );

  serial_byte_fifo #(.ADDR_W(FIFO_ADDR_W), .DATA_W(8)) rxq_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (rxDone),
    .pushData (rxByte),
    .pop      (strobe.rxPop),
    .headData (rxHead),
    .empty    (rxEmpty),
    .full     (rxFull)
  );

  serial_byte_fifo #(.ADDR_W(FIFO_ADDR_W), .DATA_W(8)) txq_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.txPush),
    .pushData (txByte),
    .pop      (txLaunch),
    .headData (txHead),
    .empty    (txEmpty),
    .full     (txFull)
  );

  serial_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) tx_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (txLaunch),
    .data  (txHead),
    .busy  (txBusy),
    .line  (txLine)
  );
endmodule

// File: rtl/serial_regctrl.sv
module serial_regctrl
  import serial_mmio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqRead,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        reqDone,
  output logic [31:0] reqRdata,
  input  logic        rxEmpty,
  input  logic [7:0]  rxHead,
  input  logic        txFull,
  input  logic        txEmpty,
  input  logic        txBusy,
  output ctrlStrobe_t strobe,
  output logic [7:0]  txByte,
  output logic        sendFlag
);
  logic        accept;
  logic        isWrite;
  logic        isRead;
  logic [2:0]  offset;
  logic [31:0] readMux;
  logic        goSet;
  logic        goClear;
  logic        unusedCtrlBits;

  assign unusedCtrlBits = ^{reqAddr[31:5], reqAddr[1:0], reqWdata[31:8]};

  // A request is taken once; the cycle its done pulse is out it is ignored
  assign accept  = (reqRead || reqWrite) && !reqDone;
  assign isWrite = reqWrite;
  assign isRead  = reqRead && !reqWrite;
  assign offset  = reqAddr[4:2];
  assign txByte  = reqWdata[7:0];

  always_comb begin
    strobe        = '0;
    strobe.rxPop  = accept && isRead && (offset == OFF_RX_DATA) && !rxEmpty;
    strobe.txPush = accept && isWrite && (offset == OFF_TX_DATA) && !txFull;
  end

  always_comb begin
    unique case (offset)
      OFF_RX_READY: readMux = {31'd0, !rxEmpty};
      OFF_RX_DATA:  readMux = rxEmpty ? 32'd0 : {24'd0, rxHead};
      OFF_TX_BUSY:  readMux = {31'd0, txBusy};
      OFF_TX_FULL:  readMux = {31'd0, txFull};
      OFF_TX_GO:    readMux = {31'd0, sendFlag};
      default:      readMux = 32'd0;
    endcase
  end

  assign goSet   = accept && isWrite && (offset == OFF_TX_GO) && reqWdata[0];
  assign goClear = sendFlag && txEmpty && !txBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqDone  <= 1'b0;
      reqRdata <= '0;
      sendFlag <= 1'b0;
    end else begin
      reqDone <= accept;
      if (accept) reqRdata <= isRead ? readMux : 32'd0;
      if (goSet) sendFlag <= 1'b1;
      else if (goClear) sendFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_mmio_port.sv
module serial_mmio_port
  import serial_mmio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 347,
  parameter int FIFO_ADDR_W  = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqRead,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  output logic        reqDone,
  output logic [31:0] reqRdata,
  input  logic        rxLine,
  output logic        txLine
);
  ctrlStrobe_t strobe;
  logic [7:0]  txByte;
  logic [7:0]  rxHead;
  logic        sendFlag;
  logic        rxEmpty;
  logic        txFull;
  logic        txEmpty;
  logic        txBusy;

  serial_regctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqRead  (reqRead),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqDone  (reqDone),
    .reqRdata (reqRdata),
    .rxEmpty  (rxEmpty),
    .rxHead   (rxHead),
    .txFull   (txFull),
    .txEmpty  (txEmpty),
    .txBusy   (txBusy),
    .strobe   (strobe),
    .txByte   (txByte),
    .sendFlag (sendFlag)
  );

  serial_datapath #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .FIFO_ADDR_W  (FIFO_ADDR_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txByte     (txByte),
    .sendActive (sendFlag),
    .rxLine     (rxLine),
    .rxHead     (rxHead),
    .rxEmpty    (rxEmpty),
    .txFull     (txFull),
    .txEmpty    (txEmpty),
    .txBusy     (txBusy),
    .txLine     (txLine)
  );
endmodule

// File: rtl/serial_mmio_port_chk.sv
module serial_mmio_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqRead,
  input logic        reqWrite,
  input logic [31:0] reqAddr,
  input logic        reqDone,
  input logic [31:0] reqRdata,
  input logic        txLine,
  input logic        txBusy,
  input logic        sendFlag,
  input logic        txEmpty,
  input logic        txFull,
  input logic        rxEmpty
);
  logic unusedChkBits;
  assign unusedChkBits = ^{reqAddr[31:5], reqAddr[1:0]};

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqRead || reqWrite) && !reqDone) |=> reqDone);

  // R11
  idle_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);

  // R10
  go_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sendFlag) |-> ($past(txEmpty) && !$past(txBusy)));

  // R9
  full_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrite && !reqDone && reqAddr[4:2] == 3'd5 && txFull && !sendFlag) |=> txFull);

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqRead && !reqWrite && !reqDone && reqAddr[4:2] == 3'd1 && rxEmpty) |=> (reqRdata == 32'd0));
endmodule

bind serial_mmio_port serial_mmio_port_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqRead  (reqRead),
  .reqWrite (reqWrite),
  .reqAddr  (reqAddr),
  .reqDone  (reqDone),
  .reqRdata (reqRdata),
  .txLine   (txLine),
  .txBusy   (txBusy),
  .sendFlag (sendFlag),
  .txEmpty  (txEmpty),
  .txFull   (txFull),
  .rxEmpty  (rxEmpty)
);

// File: tb/serial_mmio_port_tb_top.sv
module serial_mmio_port_tb_top;
  localparam int DIV   = 16;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqRead;
  logic        reqWrite;
  logic [31:0] reqAddr;
  logic [31:0] reqWdata;
  logic        reqDone;
  logic [31:0] reqRdata;
  logic        benchRx;
  logic        loopEn;
  logic        rxLine;
  logic        txLine;

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 1'b0;

  always #10 clk = ~clk;

  assign rxLine = loopEn ? txLine : benchRx;

  serial_mmio_port #(.CLKS_PER_BIT(DIV), .FIFO_ADDR_W(AW)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqRead  (reqRead),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqDone  (reqDone),
    .reqRdata (reqRdata),
    .rxLine   (rxLine),
    .txLine   (txLine)
  );

  function automatic logic [7:0] rxPat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] txPat(input int i);
    return 8'((i * 53 + 200) & 255);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busRw(input bit wr, input logic [2:0] off, input logic [31:0] wd,
                       output logic [31:0] rd);
    @(negedge clk);
    reqRead  = !wr;
    reqWrite = wr;
    reqAddr  = 32'hFFFF0120 | {27'd0, off, 2'b00};
    reqWdata = wd;
    @(negedge clk);
    check("R2 done after one cycle", {31'd0, reqDone}, 32'd1);
    rd       = reqRdata;
    reqRead  = 1'b0;
    reqWrite = 1'b0;
    @(negedge clk);
    check("R2 done is one pulse", {31'd0, reqDone}, 32'd0);
  endtask

  task automatic readReg(input logic [2:0] off, input logic [31:0] exp, input string tag);
    logic [31:0] rd;
    busRw(1'b0, off, 32'd0, rd);
    check(tag, rd, exp);
  endtask

  task automatic writeReg(input logic [2:0] off, input logic [31:0] wd);
    logic [31:0] rd;
    busRw(1'b1, off, wd, rd);
  endtask

  task automatic driveFrame(input logic [7:0] b, input logic stopBit);
    @(negedge clk);
    benchRx = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      benchRx = b[i];
      repeat (DIV) @(negedge clk);
    end
    benchRx = stopBit;
    repeat (DIV) @(negedge clk);
    benchRx = 1'b1;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic captureTx(output logic [7:0] b, output logic frameOk);
    while (txLine === 1'b1) @(negedge clk);
    repeat (DIV / 2) @(negedge clk);
    frameOk = (txLine === 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = txLine;
    end
    repeat (DIV) @(negedge clk);
    frameOk = frameOk && (txLine === 1'b1);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; reqRead = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0; benchRx = 1'b1; loopEn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 line idle high", {31'd0, txLine}, 32'd1);
    readReg(3'd0, 32'd0, "R1 ready after reset");
    readReg(3'd2, 32'd0, "R1 busy after reset");
    readReg(3'd3, 32'd0, "R1 full after reset");
    readReg(3'd4, 32'd0, "R1 go after reset");

    // R5 empty data read
    readReg(3'd1, 32'd0, "R5 empty data read");
    readReg(3'd0, 32'd0, "R5 still empty");

    // R12 unused offsets
    writeReg(3'd6, 32'hFFFF_FFFF);
    writeReg(3'd7, 32'hFFFF_FFFF);
    readReg(3'd6, 32'd0, "R12 offset 6");
    readReg(3'd7, 32'd0, "R12 offset 7");
    readReg(3'd4, 32'd0, "R12 go untouched");
    check("R12 line idle", {31'd0, txLine}, 32'd1);

    // R6 R3 R4 single frame
    driveFrame(8'hA5, 1'b1);
    readReg(3'd0, 32'd1, "R3 ready with byte");
    readReg(3'd1, 32'h0000_00A5, "R4 single byte");
    readReg(3'd0, 32'd0, "R3 ready after pop");

    // R6 short glitch
    @(negedge clk);
    benchRx = 1'b0;
    repeat (3) @(negedge clk);
    benchRx = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    readReg(3'd0, 32'd0, "R6 glitch rejected");

    // R7 bad stop bit then recovery
    driveFrame(8'h3C, 1'b0);
    readReg(3'd0, 32'd0, "R7 bad stop dropped");
    driveFrame(8'h7E, 1'b1);
    readReg(3'd1, 32'h0000_007E, "R7 next frame kept");

    // R8 R4 fill past depth
    for (int i = 0; i < DEPTH + 2; i++) driveFrame(rxPat(i), 1'b1);
    readReg(3'd0, 32'd1, "R8 ready when full");
    for (int i = 0; i < DEPTH; i++) readReg(3'd1, {24'd0, rxPat(i)}, "R4 R8 order");
    readReg(3'd0, 32'd0, "R8 extra bytes dropped");
    readReg(3'd1, 32'd0, "R5 drained read");

    // R9 fill transmit queue
    for (int i = 0; i < DEPTH; i++) begin
      readReg(3'd3, 32'd0, "R9 not full yet");
      writeReg(3'd5, {24'hABCDEF, txPat(i)});
    end
    readReg(3'd3, 32'd1, "R9 full flag");
    writeReg(3'd5, 32'h0000_00EE);
    writeReg(3'd4, 32'd0);
    repeat (2 * DIV) @(negedge clk);
    readReg(3'd4, 32'd0, "R10 write zero no effect");
    readReg(3'd2, 32'd0, "R10 nothing sent while clear");
    check("R10 line idle while clear", {31'd0, txLine}, 32'd1);

    // R10 R11 drain
    fork
      begin
        for (int i = 0; i < DEPTH; i++) begin
          logic [7:0] b;
          logic ok;
          captureTx(b, ok);
          check("R11 sent byte", {24'd0, b}, {24'd0, txPat(i)});
          check("R11 framing", {31'd0, ok}, 32'd1);
        end
      end
      begin
        writeReg(3'd4, 32'd1);
        readReg(3'd4, 32'd1, "R10 go held while draining");
        readReg(3'd2, 32'd1, "R11 busy while sending");
      end
    join
    begin
      bit stayedHigh = 1'b1;
      for (int k = 0; k < 12 * DIV; k++) begin
        @(negedge clk);
        if (txLine !== 1'b1) stayedHigh = 1'b0;
      end
      check("R9 ignored byte not sent", {31'd0, stayedHigh}, 32'd1);
    end
    readReg(3'd4, 32'd0, "R10 go cleared");
    readReg(3'd2, 32'd0, "R11 busy cleared");
    readReg(3'd3, 32'd0, "R9 full cleared");

    // R10 go with empty queue
    writeReg(3'd4, 32'd1);
    repeat (4) @(negedge clk);
    readReg(3'd4, 32'd0, "R10 empty go clears");

    // R11 loopback
    loopEn = 1'b1;
    for (int i = 0; i < 3; i++) writeReg(3'd5, {24'd0, txPat(i + 20)});
    writeReg(3'd4, 32'd1);
    repeat (3 * 11 * DIV + 40) @(negedge clk);
    for (int i = 0; i < 3; i++) readReg(3'd1, {24'd0, txPat(i + 20)}, "R11 loopback byte");
    readReg(3'd0, 32'd0, "R3 loopback drained");
    readReg(3'd4, 32'd0, "R10 loopback go cleared");

    finishRun();
  end
endmodule